// File: doc/BRIEF.md
# Pseudo-DMA Byte Port

This block gives a host processor a byte-wide data window into an internal transfer buffer when no bus-mastering DMA engine is present. Control logic arms it with a buffer start index, a byte count and a flag saying whether a completion action should follow. From then on the port raises a data-request line, and every host access through the window moves one or two bytes between the host and the buffer at a running index.

Each accepted host write also steps a shared 24-bit transfer counter down by the access size. The block presents the new counter value and a write strobe so that the counter's owner can store it. Once the armed byte count is exhausted and a completion action was armed, the port drops the request line, gives a single-cycle completion pulse and disarms. Alongside the pulse it reports how many bytes were actually moved, so that a count of zero can be recognised. Choosing which buffer is attached, and what is done after completion, is left to the surrounding logic.

Top module: `pdma_byte_port`

## Requirements
- R1: After synchronous reset, drq, done, remain_len and moved_count are all zero, and no buffer or counter write strobe is active while the host is idle.
- R2: An arm request loads the start index, the current index (equal to the start) and the remaining length. On the next cycle drq is 1 and moved_count is 0. A host access offered in the same cycle as an arm is ignored: no buf_we, no tc_we, host_rdata is zero, and the state afterwards is the armed state.
- R3: An accepted 1-byte write (host_size = 1) drives buf_we = 2'b01 with buf_addr0 equal to the current index and buf_wdata0 = host_wdata[7:0]. On the next cycle the current index is one higher and remain_len is one lower.
- R4: An accepted 2-byte write (host_size = 2) drives buf_we = 2'b11. buf_wdata0 = host_wdata[15:8] goes to buf_addr0 = the current index, and buf_wdata1 = host_wdata[7:0] goes to buf_addr1 = the current index + 1 (modulo the index width). remain_len then drops by 2 and the index advances by 2.
- R5: An accepted 1-byte read returns {8'h00, byte at the current index}. An accepted 2-byte read returns the byte at the current index in bits 15:8 and the following byte in bits 7:0. The index and remain_len advance as they do for writes of the same size, and neither buf_we nor tc_we is asserted.
- R6: A write is ignored (no buf_we, no tc_we, no state change) when tc_cur is zero or remain_len is zero. A read with remain_len zero returns 0 and changes nothing.
- R7: An accepted write asserts tc_we in the same cycle, with tc_next = tc_cur minus the access size, modulo 2^24. Reads never assert tc_we.
- R8: When an accepted access brings remain_len to zero while a completion action is armed, the next cycle shows drq = 0 and done = 1, done lasts exactly one cycle, and the action is disarmed. Without an armed action, drq stays 1 at zero length and done stays 0.
- R9: moved_count always equals the current index minus the start index, modulo the index width. It therefore counts the bytes moved since the last arm, and index wrap-around is taken into account.
- R10: An access is rejected, with no strobes and no state change, when host_size is anything other than 1 or 2, or when a 2-byte access is offered with remain_len equal to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arm_valid | input | 1 | Arm request, one cycle |
| arm_start | input | IDX_W | Buffer start index |
| arm_len | input | LEN_W | Number of bytes to move |
| arm_notify | input | 1 | A completion action follows exhaustion |
| host_valid | input | 1 | Host access strobe, one cycle per access |
| host_write | input | 1 | 1 = write, 0 = read |
| host_size | input | 3 | Access size in bytes (1 or 2 legal) |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data, same cycle |
| tc_cur | input | TC_W | Current transfer counter value |
| tc_we | output | 1 | Transfer counter write-back strobe |
| tc_next | output | TC_W | Decremented counter value |
| buf_addr0 | output | IDX_W | Buffer address, lane 0 (current index) |
| buf_addr1 | output | IDX_W | Buffer address, lane 1 (current index + 1) |
| buf_we | output | 2 | Buffer write enables per lane |
| buf_wdata0 | output | 8 | Buffer write data, lane 0 |
| buf_wdata1 | output | 8 | Buffer write data, lane 1 |
| buf_rdata0 | input | 8 | Buffer read data at buf_addr0 |
| buf_rdata1 | input | 8 | Buffer read data at buf_addr1 |
| drq | output | 1 | Data request while a transfer is armed |
| done | output | 1 | Single-cycle completion pulse |
| remain_len | output | LEN_W | Bytes still to move |
| moved_count | output | IDX_W | Bytes moved since the last arm |

## Verification
An arm and a host access can land in the same clock cycle, and so can a final access and a fresh arm during the completion pulse. The bench provokes the first case by offering a write together with an arm. It then judges, on that cycle and the next, that no lane or counter strobe appeared and that the loaded index and length are exactly the armed ones. The last byte of a transfer and the counter write-back also fall in one cycle. That is checked by comparing tc_next, buf_we and the following cycle's drq and done against the behavioural model on every clock.

// File: rtl/pdma_pkg.sv
package pdma_pkg;

    localparam int LANES  = 2;
    localparam int LANE_W = 8;
    localparam int DATA_W = LANES * LANE_W;

    localparam logic [2:0] SIZE_BYTE = 3'd1;
    localparam logic [2:0] SIZE_HALF = 3'd2;

    typedef struct packed {
        logic              accept;
        logic              is_write;
        logic [1:0]        step;
        logic [LANES-1:0]  lane_we;
    } access_t;

    function automatic logic size_is_legal(input logic [2:0] sz);
        return (sz == SIZE_BYTE) || (sz == SIZE_HALF);
    endfunction

    function automatic logic [1:0] size_step(input logic [2:0] sz);
        return (sz == SIZE_HALF) ? 2'd2 : 2'd1;
    endfunction

    function automatic logic [LANES-1:0] lanes_for(input logic [2:0] sz);
        return (sz == SIZE_HALF) ? 2'b11 : 2'b01;
    endfunction

endpackage

// File: rtl/pdma_access_decode.sv
module pdma_access_decode
    import pdma_pkg::*;
#(
    parameter int IDX_W = 8,
    parameter int LEN_W = 9
) (
    input  logic                  arm_valid,
    input  logic                  host_valid,
    input  logic                  host_write,
    input  logic [2:0]            host_size,
    input  logic [DATA_W-1:0]     host_wdata,
    input  logic [LEN_W-1:0]      remain,
    input  logic                  tc_zero,
    input  logic [IDX_W-1:0]      cur_idx,
    input  logic [LANE_W-1:0]     rd_lane0,
    input  logic [LANE_W-1:0]     rd_lane1,
    output access_t               acc,
    output logic [DATA_W-1:0]     host_rdata,
    output logic [IDX_W-1:0]      lane_addr0,
    output logic [IDX_W-1:0]      lane_addr1,
    output logic [LANE_W-1:0]     lane_wdata0,
    output logic [LANE_W-1:0]     lane_wdata1
);

    logic [IDX_W-1:0]  addr_a  [LANES];
    logic [LANE_W-1:0] wdat_a  [LANES];
    logic              is_half;
    logic              room_ok;
    logic              write_ok;

    assign is_half  = (host_size == SIZE_HALF);
    assign room_ok  = remain >= LEN_W'(size_step(host_size));
    assign write_ok = !host_write || !tc_zero;

    always_comb begin
        acc          = '0;
        acc.is_write = host_write;
        acc.step     = size_step(host_size);
        acc.accept   = host_valid && !arm_valid && size_is_legal(host_size)
                       && room_ok && write_ok;
        acc.lane_we  = (acc.accept && host_write) ? lanes_for(host_size) : '0;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign addr_a[g] = cur_idx + IDX_W'(g);
        // halfword is split high byte first; a single byte rides lane 0
        assign wdat_a[g] = is_half ? host_wdata[(LANES-1-g)*LANE_W +: LANE_W]
                                   : host_wdata[g*LANE_W +: LANE_W];
    end

    assign lane_addr0  = addr_a[0];
    assign lane_addr1  = addr_a[1];
    assign lane_wdata0 = wdat_a[0];
    assign lane_wdata1 = wdat_a[1];

    always_comb begin
        host_rdata = '0;
        if (acc.accept && !host_write) begin
            host_rdata = is_half ? {rd_lane0, rd_lane1} : {8'h00, rd_lane0};
        end
    end

endmodule

// File: rtl/pdma_window_state.sv
module pdma_window_state
    import pdma_pkg::*;
#(
    parameter int IDX_W = 8,
    parameter int LEN_W = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              arm_valid,
    input  logic [IDX_W-1:0]  arm_start,
    input  logic [LEN_W-1:0]  arm_len,
    input  logic              arm_notify,
    input  access_t           acc,
    output logic [IDX_W-1:0]  cur_idx,
    output logic [IDX_W-1:0]  start_idx,
    output logic [LEN_W-1:0]  remain,
    output logic              drq,
    output logic              done
);

    logic             notify_q;
    logic [LEN_W-1:0] step_l;
    logic             last_one;

    assign step_l   = LEN_W'(acc.step);
    assign last_one = acc.accept && (remain == step_l);

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_idx   <= '0;
            start_idx <= '0;
            remain    <= '0;
            notify_q  <= 1'b0;
            drq       <= 1'b0;
            done      <= 1'b0;
        end else if (arm_valid) begin
            cur_idx   <= arm_start;
            start_idx <= arm_start;
            remain    <= arm_len;
            notify_q  <= arm_notify;
            drq       <= 1'b1;
            done      <= 1'b0;
        end else begin
            done <= 1'b0;
            if (acc.accept) begin
                cur_idx <= cur_idx + IDX_W'(acc.step);
                remain  <= remain - step_l;
            end
            if (last_one && notify_q) begin
                drq      <= 1'b0;
                done     <= 1'b1;
                notify_q <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/pdma_tc_update.sv
module pdma_tc_update
    import pdma_pkg::*;
#(
    parameter int TC_W = 24
) (
    input  logic [TC_W-1:0] tc_cur,
    input  access_t         acc,
    output logic            tc_zero,
    output logic            tc_we,
    output logic [TC_W-1:0] tc_next
);

    assign tc_zero = (tc_cur == '0);
    assign tc_we   = acc.accept && acc.is_write;
    assign tc_next = tc_cur - TC_W'(acc.step);

endmodule

// File: rtl/pdma_byte_port.sv
module pdma_byte_port
    import pdma_pkg::*;
#(
    parameter int IDX_W = 8,
    parameter int LEN_W = 9,
    parameter int TC_W  = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             arm_valid,
    input  logic [IDX_W-1:0] arm_start,
    input  logic [LEN_W-1:0] arm_len,
    input  logic             arm_notify,
    input  logic             host_valid,
    input  logic             host_write,
    input  logic [2:0]       host_size,
    input  logic [15:0]      host_wdata,
    output logic [15:0]      host_rdata,
    input  logic [TC_W-1:0]  tc_cur,
    output logic             tc_we,
    output logic [TC_W-1:0]  tc_next,
    output logic [IDX_W-1:0] buf_addr0,
    output logic [IDX_W-1:0] buf_addr1,
    output logic [1:0]       buf_we,
    output logic [7:0]       buf_wdata0,
    output logic [7:0]       buf_wdata1,
    input  logic [7:0]       buf_rdata0,
    input  logic [7:0]       buf_rdata1,
    output logic             drq,
    output logic             done,
    output logic [LEN_W-1:0] remain_len,
    output logic [IDX_W-1:0] moved_count
);

    access_t          acc;
    logic             tc_zero;
    logic [IDX_W-1:0] cur_idx;
    logic [IDX_W-1:0] start_idx;

    pdma_access_decode #(.IDX_W(IDX_W), .LEN_W(LEN_W)) u_decode (
        .arm_valid   (arm_valid),
        .host_valid  (host_valid),
        .host_write  (host_write),
        .host_size   (host_size),
        .host_wdata  (host_wdata),
        .remain      (remain_len),
        .tc_zero     (tc_zero),
        .cur_idx     (cur_idx),
        .rd_lane0    (buf_rdata0),
        .rd_lane1    (buf_rdata1),
        .acc         (acc),
        .host_rdata  (host_rdata),
        .lane_addr0  (buf_addr0),
        .lane_addr1  (buf_addr1),
        .lane_wdata0 (buf_wdata0),
        .lane_wdata1 (buf_wdata1)
    );

    pdma_window_state #(.IDX_W(IDX_W), .LEN_W(LEN_W)) u_state (
        .clk        (clk),
        .rst        (rst),
        .arm_valid  (arm_valid),
        .arm_start  (arm_start),
        .arm_len    (arm_len),
        .arm_notify (arm_notify),
        .acc        (acc),
        .cur_idx    (cur_idx),
        .start_idx  (start_idx),
        .remain     (remain_len),
        .drq        (drq),
        .done       (done)
    );

    pdma_tc_update #(.TC_W(TC_W)) u_tc (
        .tc_cur  (tc_cur),
        .acc     (acc),
        .tc_zero (tc_zero),
        .tc_we   (tc_we),
        .tc_next (tc_next)
    );

    assign buf_we      = acc.lane_we;
    assign moved_count = cur_idx - start_idx;

endmodule

// File: rtl/pdma_byte_port_chk.sv
module pdma_byte_port_chk #(
    parameter int IDX_W = 8,
    parameter int LEN_W = 9,
    parameter int TC_W  = 24
) (
    input logic             clk,
    input logic             rst,
    input logic             arm_valid,
    input logic [LEN_W-1:0] arm_len,
    input logic             host_valid,
    input logic             host_write,
    input logic [2:0]       host_size,
    input logic [TC_W-1:0]  tc_cur,
    input logic             tc_we,
    input logic [1:0]       buf_we,
    input logic             drq,
    input logic             done,
    input logic [LEN_W-1:0] remain_len,
    input logic [IDX_W-1:0] moved_count
);

    localparam logic [LEN_W-1:0] ONE_L = LEN_W'(1);
    localparam logic [LEN_W-1:0] TWO_L = LEN_W'(2);

    // R2
    p_arm_loads_r2: assert property (@(posedge clk) disable iff (rst)
        arm_valid |=> (drq && remain_len == $past(arm_len) && moved_count == '0));
    p_arm_blocks_access_r2: assert property (@(posedge clk) disable iff (rst)
        arm_valid |-> (buf_we == 2'b00 && !tc_we));
    // R3
    p_byte_step_r3: assert property (@(posedge clk) disable iff (rst)
        (buf_we == 2'b01) |=> (remain_len == $past(remain_len) - ONE_L));
    // R4
    p_half_step_r4: assert property (@(posedge clk) disable iff (rst)
        (buf_we == 2'b11) |=> (remain_len == $past(remain_len) - TWO_L));
    // R6
    p_no_write_tc_zero_r6: assert property (@(posedge clk) disable iff (rst)
        (host_valid && host_write && tc_cur == '0) |-> (buf_we == 2'b00 && !tc_we));
    // R7
    p_tc_only_writes_r7: assert property (@(posedge clk) disable iff (rst)
        tc_we |-> (host_valid && host_write && buf_we != 2'b00));
    // R8
    p_done_single_r8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    p_done_drops_drq_r8: assert property (@(posedge clk) disable iff (rst)
        done |-> !drq);
    // R10
    p_bad_size_r10: assert property (@(posedge clk) disable iff (rst)
        (host_valid && !arm_valid && host_size != 3'd1 && host_size != 3'd2)
        |=> $stable(remain_len));

endmodule

bind pdma_byte_port pdma_byte_port_chk #(.IDX_W(IDX_W), .LEN_W(LEN_W), .TC_W(TC_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .arm_valid   (arm_valid),
    .arm_len     (arm_len),
    .host_valid  (host_valid),
    .host_write  (host_write),
    .host_size   (host_size),
    .tc_cur      (tc_cur),
    .tc_we       (tc_we),
    .buf_we      (buf_we),
    .drq         (drq),
    .done        (done),
    .remain_len  (remain_len),
    .moved_count (moved_count)
);

// File: tb/test_pdma_byte_port.sv
`timescale 1ns/1ps
module test_pdma_byte_port;

    logic        clk = 1'b0;
    logic        rst;
    logic        arm_valid;
    logic [7:0]  arm_start;
    logic [8:0]  arm_len;
    logic        arm_notify;
    logic        host_valid;
    logic        host_write;
    logic [2:0]  host_size;
    logic [15:0] host_wdata;
    logic [15:0] host_rdata;
    logic [23:0] tc_cur;
    logic        tc_we;
    logic [23:0] tc_next;
    logic [7:0]  buf_addr0, buf_addr1;
    logic [1:0]  buf_we;
    logic [7:0]  buf_wdata0, buf_wdata1;
    logic [7:0]  buf_rdata0, buf_rdata1;
    logic        drq, done;
    logic [8:0]  remain_len;
    logic [7:0]  moved_count;

    logic [7:0] mem [256];
    assign buf_rdata0 = mem[buf_addr0];
    assign buf_rdata1 = mem[buf_addr1];

    always #2.5 clk = ~clk;

    pdma_byte_port i_pdma_byte_port (
        .clk(clk), .rst(rst),
        .arm_valid(arm_valid), .arm_start(arm_start), .arm_len(arm_len), .arm_notify(arm_notify),
        .host_valid(host_valid), .host_write(host_write), .host_size(host_size),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .tc_cur(tc_cur), .tc_we(tc_we), .tc_next(tc_next),
        .buf_addr0(buf_addr0), .buf_addr1(buf_addr1), .buf_we(buf_we),
        .buf_wdata0(buf_wdata0), .buf_wdata1(buf_wdata1),
        .buf_rdata0(buf_rdata0), .buf_rdata1(buf_rdata1),
        .drq(drq), .done(done), .remain_len(remain_len), .moved_count(moved_count)
    );

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;

    // behavioural reference state
    int m_cur, m_start, m_rem;
    bit m_notify, m_drq, m_done;

    task automatic chk(string tag, string what, longint act, longint exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic idle();
        arm_valid = 0; arm_start = 0; arm_len = 0; arm_notify = 0;
        host_valid = 0; host_write = 0; host_size = 0; host_wdata = 0;
    endtask

    // compare every output for the current cycle, then advance one clock
    task automatic step(string tag);
        bit acc;
        int sz;
        int exp_we, exp_rd;
        logic [1:0] cap_we;
        logic [7:0] cap_a0, cap_a1, cap_d0, cap_d1;
        #1;
        sz  = host_size;
        acc = host_valid && !arm_valid && (sz == 1 || sz == 2) && (m_rem >= sz)
              && (!host_write || tc_cur != 0);
        exp_we = (acc && host_write) ? ((sz == 2) ? 3 : 1) : 0;
        exp_rd = 0;
        if (acc && !host_write)
            exp_rd = (sz == 2) ? {mem[m_cur[7:0]], mem[8'(m_cur + 1)]} : {8'h00, mem[m_cur[7:0]]};
        chk(tag, "drq", drq, m_drq);
        chk(tag, "done", done, m_done);
        chk(tag, "remain_len", remain_len, m_rem);
        chk(tag, "moved_count", moved_count, (m_cur - m_start) & 8'hff);
        chk(tag, "buf_we", buf_we, exp_we);
        chk(tag, "tc_we", tc_we, (acc && host_write) ? 1 : 0);
        chk(tag, "host_rdata", host_rdata, exp_rd);
        if (acc) begin
            chk(tag, "buf_addr0", buf_addr0, m_cur & 8'hff);
            chk(tag, "buf_addr1", buf_addr1, (m_cur + 1) & 8'hff);
        end
        if (exp_we != 0) begin
            chk(tag, "buf_wdata0", buf_wdata0, (sz == 2) ? host_wdata[15:8] : host_wdata[7:0]);
            if (sz == 2) chk(tag, "buf_wdata1", buf_wdata1, host_wdata[7:0]);
            chk(tag, "tc_next", tc_next, (tc_cur - sz) & 24'hffffff);
        end
        cap_we = buf_we; cap_a0 = buf_addr0; cap_a1 = buf_addr1;
        cap_d0 = buf_wdata0; cap_d1 = buf_wdata1;
        @(posedge clk);
        if (cap_we[0]) mem[cap_a0] = cap_d0;
        if (cap_we[1]) mem[cap_a1] = cap_d1;
        if (rst) begin
            m_cur = 0; m_start = 0; m_rem = 0; m_notify = 0; m_drq = 0; m_done = 0;
        end else if (arm_valid) begin
            m_cur = arm_start; m_start = arm_start; m_rem = arm_len;
            m_notify = arm_notify; m_drq = 1; m_done = 0;
        end else begin
            m_done = 0;
            if (acc) begin
                m_cur = (m_cur + sz) & 8'hff;
                m_rem = m_rem - sz;
                if (m_rem == 0 && m_notify) begin
                    m_drq = 0; m_done = 1; m_notify = 0;
                end
            end
        end
        @(negedge clk);
    endtask

    task automatic arm(int start, int len, bit notify);
        idle();
        arm_valid = 1; arm_start = 8'(start); arm_len = 9'(len); arm_notify = notify;
    endtask

    task automatic host(bit wr, int sz, int data);
        idle();
        host_valid = 1; host_write = wr; host_size = 3'(sz); host_wdata = 16'(data);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fails++;
            $display("FAIL R1 watchdog actual=expired expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 3);
        m_cur = 0; m_start = 0; m_rem = 0; m_notify = 0; m_drq = 0; m_done = 0;
        idle(); tc_cur = 24'd100; rst = 1;
        @(negedge clk);
        step("R1"); step("R1");
        rst = 0;
        idle(); step("R1");

        // arm with a write offered in the same cycle: the arm wins
        arm(10, 4, 1); host_valid = 1; host_write = 1; host_size = 1; host_wdata = 16'h00ee;
        step("R2");
        idle(); step("R2");

        host(1, 1, 16'h77a5); step("R3");
        host(1, 2, 16'h1234); tc_cur = 24'd99; step("R4");
        host(1, 2, 16'h5566); step("R10");          // halfword with one byte left
        host(1, 4, 16'h5566); step("R10");          // illegal width
        host(1, 1, 16'h00c3); tc_cur = 24'd97; step("R7");
        idle(); step("R8");                         // done pulse, drq low
        idle(); step("R8");                         // done gone
        host(1, 1, 16'h0011); step("R6");           // zero length: ignored
        host(0, 1, 0); step("R6");                  // zero length read returns 0

        // readback with no completion action
        arm(10, 4, 0); step("R5");
        host(0, 2, 0); step("R5");
        host(0, 0, 0); step("R10");
        host(0, 1, 0); step("R5");
        host(0, 1, 0); step("R9");
        idle(); step("R8");                         // drq stays high at zero
        idle(); step("R9");

        // counter at zero blocks writes, reads still proceed
        arm(40, 3, 1); tc_cur = 24'd0; step("R2");
        host(1, 1, 16'h00aa); step("R6");
        host(1, 2, 16'hbbcc); step("R6");
        host(0, 1, 0); step("R5");
        // counter wrap on a halfword write
        tc_cur = 24'd1; host(1, 2, 16'hdead); step("R7");
        idle(); step("R8");

        // index wrap-around across the buffer end
        arm(255, 2, 1); tc_cur = 24'h000200; step("R2");
        host(1, 2, 16'hbeef); step("R9");
        idle(); step("R9");
        idle(); step("R9");
        host(0, 2, 0); step("R6");

        // re-arm during the completion pulse
        arm(5, 1, 1); step("R2");
        host(1, 1, 16'h0042); step("R3");
        arm(6, 2, 1); step("R2");                   // done visible here, arm taken
        idle(); step("R2");

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

endmodule